// File: doc/BRIEF.md
# Floating-Point State-Enable Access Checker

This block keeps three 64-bit state-enable registers: a machine-level one, a hypervisor-level one and a supervisor-level one. From them it rules whether a floating-point instruction, or an access to the FP control/status register, may go ahead. The ruling matters on a hart whose floating-point values live in the integer register file and which has no single-precision FP register file. A decode stage raises a check request together with the hart's current privilege, virtualization mode and configuration flags. In the same cycle the block answers with one of three verdicts: allow, illegal-instruction fault, or virtual-instruction fault.

A software CSR path writes the registers through one port. The port does either a full 64-bit write or an upper-half write, the latter being the alias used by 32-bit software. A write mask decides which bits a write may change, and the mask depends on whether the single-precision FP extension is present. Any register can be read back combinationally.

Top module: `fpse_gate`

## Requirements
- R1: After reset all three registers read zero. A valid instruction check then made in supervisor mode, with the state-enable extension and integer-register FP present and no single-precision FP, yields an illegal-instruction fault.
- R2: A full write (`wr_hi`=0) to a register changes only bit 63 (state-enable), bit 62 (hypervisor env-config) and bit 1 (FP CSR enable). Every other bit keeps reading zero. Bit 1 is writable only while `has_f`=0; with `has_f`=1 it keeps its old value. The `wr_sel` codes are 0 machine, 1 hypervisor, 2 supervisor and 3 none; a write with code 3 changes nothing.
- R3: An upper-half write (`wr_hi`=1) places `wr_data[31:0]` into bits 63:32 under the same mask, so only bits 63 and 62 can change. Bits 31:0 are left unchanged.
- R4: When a check is valid and both `has_f` and `has_fx` are 0, the verdict is illegal-instruction.
- R5: When a check is valid and `has_f`=1, the verdict is allow, whatever the registers hold.
- R6: With `has_f`=0 and `has_fx`=1, the verdict is allow when `has_stateen`=0 or when `priv` is machine. The `priv` codes are 0 user, 1 supervisor, 2 reserved (treated like supervisor) and 3 machine.
- R7: Otherwise the effective enable starts as bit 1 of the machine register. It is ANDed with bit 1 of the hypervisor register when `virt_mode`=1, and with bit 1 of the supervisor register when `priv` is user and `has_s`=1. If the result is 1 the verdict is allow.
- R8: When the effective enable of R7 is 0, the fault is virtual-instruction if `virt_mode`=1 and illegal-instruction otherwise.
- R9: For a CSR check (`chk_csr`=1) with `has_f`=0 and `has_fx`=1, a set `dbg_access` or a set `fp_on` gives allow without consulting the registers.
- R10: While `chk_valid`=1 exactly one of `allow`, `fault_illegal` and `fault_virtual` is 1. While `chk_valid`=0 all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CSR write strobe |
| wr_sel | input | 2 | Target register: 0 machine, 1 hypervisor, 2 supervisor, 3 none |
| wr_hi | input | 1 | 1 selects the upper-half alias write |
| wr_data | input | 64 | Write data (low 32 bits used for upper-half writes) |
| rd_sel | input | 2 | Register shown on rd_data (same codes; 3 reads zero) |
| rd_data | output | 64 | Selected register contents |
| chk_valid | input | 1 | Check request valid |
| chk_csr | input | 1 | 1 for an FP CSR access, 0 for an FP instruction |
| priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt_mode | input | 1 | Hart is running virtualized |
| has_stateen | input | 1 | State-enable extension implemented |
| has_f | input | 1 | Single-precision FP extension present |
| has_fx | input | 1 | FP-in-integer-register extension present |
| has_s | input | 1 | Supervisor mode implemented |
| dbg_access | input | 1 | CSR access comes from the debugger |
| fp_on | input | 1 | FP state currently enabled |
| allow | output | 1 | Access permitted |
| fault_illegal | output | 1 | Illegal-instruction fault |
| fault_virtual | output | 1 | Virtual-instruction fault |

## Verification
The bench builds the block with its default parameters: 64-bit registers, enable bits at 1, 62 and 63, and the upper-half alias present. With that build, the split between the two write forms at bit 32 can be seen through the read port, and the mask rule can be tried with the single-precision flag toggled between writes. Random runs cover all privilege codes, including the reserved one, with virtualization and extension flags mixed freely. This reaches every combination in which one of the three layers removes the enable while the other two grant it.

// File: rtl/fpse_pkg.sv
package fpse_pkg;

   typedef enum logic [1:0] {
      PRIV_U   = 2'd0,
      PRIV_S   = 2'd1,
      PRIV_RSV = 2'd2,
      PRIV_M   = 2'd3
   } priv_e;

   typedef enum logic [1:0] {
      SEL_MACH = 2'd0,
      SEL_HYP  = 2'd1,
      SEL_SUP  = 2'd2,
      SEL_NONE = 2'd3
   } regsel_e;

   // Number of enable layers held by the block.
   localparam int unsigned NUM_LAYERS = 3;

   typedef struct packed {
      logic allow;
      logic illegal;
      logic virt_fault;
   } verdict_t;

endpackage

// File: rtl/fpse_enable_reg.sv
module fpse_enable_reg #(
   parameter int unsigned REG_W          = 64,
   parameter int unsigned FCSR_POS       = 1,
   parameter int unsigned ENVCFG_POS     = 62,
   parameter int unsigned STATEEN_POS    = 63,
   parameter bit          HAS_HALF_ALIAS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_hi,
   input  logic [REG_W-1:0] wr_data,
   input  logic             fp_single_present,
   output logic [REG_W-1:0] q
);

   localparam int unsigned HALF_W = REG_W / 2;

   logic [REG_W-1:0] wmask;
   logic [REG_W-1:0] full_next;
   logic [REG_W-1:0] half_next;
   logic [REG_W-1:0] nxt;

   always_comb begin
      wmask              = '0;
      wmask[STATEEN_POS] = 1'b1;
      wmask[ENVCFG_POS]  = 1'b1;
      wmask[FCSR_POS]    = !fp_single_present;
   end

   assign full_next = (q & ~wmask) | (wr_data & wmask);

   generate
      if (HAS_HALF_ALIAS) begin : g_alias
         logic [REG_W-1:0] hmask;
         logic [REG_W-1:0] hdata;
         assign hmask     = {wmask[REG_W-1:HALF_W], {HALF_W{1'b0}}};
         assign hdata     = {wr_data[HALF_W-1:0], {HALF_W{1'b0}}};
         assign half_next = (q & ~hmask) | (hdata & hmask);
      end else begin : g_no_alias
         assign half_next = q;
      end
   endgenerate

   assign nxt = wr_hi ? half_next : full_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr_en) begin
         q <= nxt;
      end
   end

endmodule

// File: rtl/fpse_eff_combine.sv
module fpse_eff_combine #(
   parameter int unsigned NL = 3
) (
   input  logic [NL-1:0] layer_bit,
   input  logic [NL-1:0] layer_used,
   output logic          eff
);

   logic [NL:0] chain;

   assign chain[0] = 1'b1;

   generate
      for (genvar l = 0; l < NL; l++) begin : g_layer
         assign chain[l+1] = chain[l] & (layer_bit[l] | ~layer_used[l]);
      end
   endgenerate

   assign eff = chain[NL];

endmodule

// File: rtl/fpse_decide.sv
module fpse_decide
   import fpse_pkg::*;
(
   input  logic     valid,
   input  logic     is_csr,
   input  logic     has_f,
   input  logic     has_fx,
   input  logic     has_stateen,
   input  logic     priv_is_m,
   input  logic     virt_mode,
   input  logic     dbg_access,
   input  logic     fp_on,
   input  logic     eff_enable,
   output verdict_t verdict
);

   logic csr_bypass;
   logic no_gate;

   assign csr_bypass = is_csr & (dbg_access | fp_on);
   assign no_gate    = !has_stateen | priv_is_m;

   always_comb begin
      verdict = '0;
      if (valid) begin
         if (has_f) begin
            verdict.allow = 1'b1;
         end else if (!has_fx) begin
            verdict.illegal = 1'b1;
         end else if (csr_bypass || no_gate || eff_enable) begin
            verdict.allow = 1'b1;
         end else if (virt_mode) begin
            verdict.virt_fault = 1'b1;
         end else begin
            verdict.illegal = 1'b1;
         end
      end
   end

endmodule

// File: rtl/fpse_gate.sv
module fpse_gate
   import fpse_pkg::*;
#(
   parameter int unsigned REG_W          = 64,
   parameter int unsigned FCSR_POS       = 1,
   parameter int unsigned ENVCFG_POS     = 62,
   parameter int unsigned STATEEN_POS    = 63,
   parameter bit          HAS_HALF_ALIAS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic             wr_hi,
   input  logic [REG_W-1:0] wr_data,
   input  logic [1:0]       rd_sel,
   output logic [REG_W-1:0] rd_data,
   input  logic             chk_valid,
   input  logic             chk_csr,
   input  logic [1:0]       priv,
   input  logic             virt_mode,
   input  logic             has_stateen,
   input  logic             has_f,
   input  logic             has_fx,
   input  logic             has_s,
   input  logic             dbg_access,
   input  logic             fp_on,
   output logic             allow,
   output logic             fault_illegal,
   output logic             fault_virtual
);

   localparam int unsigned NL = NUM_LAYERS;

   generate
      if ((REG_W % 2) != 0 || REG_W < 4) begin : g_bad_width
         $error("fpse_gate: REG_W must be even and at least 4");
      end
      if (FCSR_POS >= REG_W || ENVCFG_POS >= REG_W || STATEEN_POS >= REG_W) begin : g_bad_pos
         $error("fpse_gate: bit positions must lie inside the register");
      end
      if (FCSR_POS == ENVCFG_POS || FCSR_POS == STATEEN_POS || ENVCFG_POS == STATEEN_POS) begin : g_dup_pos
         $error("fpse_gate: bit positions must be distinct");
      end
   endgenerate

   logic [NL-1:0][REG_W-1:0] layer_q;
   logic [NL-1:0]            layer_fcsr;
   logic [NL-1:0]            layer_used;
   logic                     eff_enable;
   priv_e                    priv_lvl;
   verdict_t                 verdict;

   assign priv_lvl = priv_e'(priv);

   generate
      for (genvar g = 0; g < NL; g++) begin : g_reg
         fpse_enable_reg #(
            .REG_W          (REG_W),
            .FCSR_POS       (FCSR_POS),
            .ENVCFG_POS     (ENVCFG_POS),
            .STATEEN_POS    (STATEEN_POS),
            .HAS_HALF_ALIAS (HAS_HALF_ALIAS)
         ) u_reg (
            .clk               (clk),
            .rst_n             (rst_n),
            .wr_en             (wr_en && (wr_sel == 2'(g))),
            .wr_hi             (wr_hi),
            .wr_data           (wr_data),
            .fp_single_present (has_f),
            .q                 (layer_q[g])
         );
         assign layer_fcsr[g] = layer_q[g][FCSR_POS];
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NL; i++) begin
         if (rd_sel == 2'(i)) rd_data = layer_q[i];
      end
   end

   // Machine layer always counts; hypervisor under virtualization;
   // supervisor for user mode on a hart with supervisor mode.
   assign layer_used[SEL_MACH] = 1'b1;
   assign layer_used[SEL_HYP]  = virt_mode;
   assign layer_used[SEL_SUP]  = (priv_lvl == PRIV_U) && has_s;

   fpse_eff_combine #(.NL(NL)) u_comb (
      .layer_bit  (layer_fcsr),
      .layer_used (layer_used),
      .eff        (eff_enable)
   );

   fpse_decide u_dec (
      .valid       (chk_valid),
      .is_csr      (chk_csr),
      .has_f       (has_f),
      .has_fx      (has_fx),
      .has_stateen (has_stateen),
      .priv_is_m   (priv_lvl == PRIV_M),
      .virt_mode   (virt_mode),
      .dbg_access  (dbg_access),
      .fp_on       (fp_on),
      .eff_enable  (eff_enable),
      .verdict     (verdict)
   );

   assign allow         = verdict.allow;
   assign fault_illegal = verdict.illegal;
   assign fault_virtual = verdict.virt_fault;

endmodule

// File: rtl/fpse_gate_chk.sv
module fpse_gate_chk #(
   parameter int unsigned REG_W    = 64,
   parameter int unsigned FCSR_POS = 1,
   parameter int unsigned NL       = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic [1:0]               wr_sel,
   input logic                     wr_hi,
   input logic [NL-1:0][REG_W-1:0] layer_q,
   input logic                     chk_valid,
   input logic [1:0]               priv,
   input logic                     virt_mode,
   input logic                     has_stateen,
   input logic                     has_f,
   input logic                     has_fx,
   input logic                     allow,
   input logic                     fault_illegal,
   input logic                     fault_virtual
);

   localparam int unsigned HALF_W = REG_W / 2;

   assert_one_verdict_R10: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |-> ($countones({allow, fault_illegal, fault_virtual}) == 1));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |-> !(allow || fault_illegal || fault_virtual));

   assert_no_fp_illegal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && !has_f && !has_fx) |-> fault_illegal);

   assert_single_allows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && has_f) |-> allow);

   assert_ungated_allows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && !has_f && has_fx && (!has_stateen || priv == 2'd3)) |-> allow);

   assert_virt_fault_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_virtual |-> virt_mode);

   generate
      for (genvar g = 0; g < NL; g++) begin : g_regchk
         assert_fcsr_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == 2'(g) && has_f) |=> $stable(layer_q[g][FCSR_POS]));
         assert_other_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!(wr_en && wr_sel == 2'(g))) |=> $stable(layer_q[g]));
         assert_half_keeps_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_sel == 2'(g) && wr_hi) |=> $stable(layer_q[g][HALF_W-1:0]));
      end
   endgenerate

endmodule

bind fpse_gate fpse_gate_chk #(
   .REG_W    (REG_W),
   .FCSR_POS (FCSR_POS),
   .NL       (NL)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_en         (wr_en),
   .wr_sel        (wr_sel),
   .wr_hi         (wr_hi),
   .layer_q       (layer_q),
   .chk_valid     (chk_valid),
   .priv          (priv),
   .virt_mode     (virt_mode),
   .has_stateen   (has_stateen),
   .has_f         (has_f),
   .has_fx        (has_fx),
   .allow         (allow),
   .fault_illegal (fault_illegal),
   .fault_virtual (fault_virtual)
);

// File: tb/tb_fpse_gate.sv
module tb_fpse_gate;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic        wr_hi = 1'b0;
   logic [63:0] wr_data = '0;
   logic [1:0]  rd_sel = '0;
   logic [63:0] rd_data;
   logic        chk_valid = 1'b0, chk_csr = 1'b0;
   logic [1:0]  priv = '0;
   logic        virt_mode = 1'b0, has_stateen = 1'b0, has_f = 1'b0, has_fx = 1'b0;
   logic        has_s = 1'b0, dbg_access = 1'b0, fp_on = 1'b0;
   logic        allow, fault_illegal, fault_virtual;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   logic [63:0] model [3];

   always #(CLK_PERIOD/2) clk = ~clk;

   fpse_gate dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_hi(wr_hi),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .chk_valid(chk_valid), .chk_csr(chk_csr), .priv(priv), .virt_mode(virt_mode),
      .has_stateen(has_stateen), .has_f(has_f), .has_fx(has_fx), .has_s(has_s),
      .dbg_access(dbg_access), .fp_on(fp_on),
      .allow(allow), .fault_illegal(fault_illegal), .fault_virtual(fault_virtual)
   );

   function automatic logic [63:0] exp_mask(input logic f, input logic hi);
      logic [63:0] m;
      m = 64'hC000_0000_0000_0000 | (f ? 64'h0 : 64'h2);
      if (hi) m = m & 64'hFFFF_FFFF_0000_0000;
      return m;
   endfunction

   // {allow, illegal, virtual}
   function automatic logic [2:0] exp_verdict();
      logic e;
      if (!chk_valid) return 3'b000;
      if (has_f) return 3'b100;
      if (!has_fx) return 3'b010;
      if (chk_csr && (dbg_access || fp_on)) return 3'b100;
      if (!has_stateen || priv == 2'd3) return 3'b100;
      e = model[0][1];
      if (virt_mode) e = e & model[1][1];
      if (priv == 2'd0 && has_s) e = e & model[2][1];
      if (e) return 3'b100;
      return virt_mode ? 3'b001 : 3'b010;
   endfunction

   task automatic check_verdict(input string tag);
      logic [2:0] got, exp;
      got = {allow, fault_illegal, fault_virtual};
      exp = exp_verdict();
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s verdict got=%b exp=%b", tag, got, exp);
      end
   endtask

   task automatic check_reg(input string tag, input int sel, input logic [63:0] exp);
      @(negedge clk);
      rd_sel = 2'(sel);
      #1;
      checks++;
      if (rd_data !== exp) begin
         failures++;
         $display("FAIL %s reg%0d got=%h exp=%h", tag, sel, rd_data, exp);
      end
   endtask

   task automatic do_write(input int sel, input logic hi, input logic [63:0] d, input logic f);
      logic [63:0] m, wd;
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'(sel); wr_hi = hi; wr_data = d; has_f = f;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      if (sel < 3) begin
         m  = exp_mask(f, hi);
         wd = hi ? {d[31:0], 32'h0} : d;
         model[sel] = (model[sel] & ~m) | (wd & m);
      end
   endtask

   task automatic set_chk(input logic v, input logic csr, input logic [1:0] p, input logic vm,
                          input logic st, input logic f, input logic fx, input logic s,
                          input logic dbg, input logic fpo);
      @(negedge clk);
      chk_valid = v; chk_csr = csr; priv = p; virt_mode = vm; has_stateen = st;
      has_f = f; has_fx = fx; has_s = s; dbg_access = dbg; fp_on = fpo;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 3; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset contents and verdict
      for (int i = 0; i < 3; i++) check_reg("R1", i, 64'h0);
      set_chk(1, 0, 2'd1, 0, 1, 0, 1, 1, 0, 0);
      check_verdict("R1");

      // R2: full write masked, FCSR writable with no single-precision FP
      do_write(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
      check_reg("R2", 0, 64'hC000_0000_0000_0002);
      do_write(0, 0, 64'h0, 1);
      check_reg("R2", 0, 64'h0000_0000_0000_0002);
      do_write(3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
      for (int i = 0; i < 3; i++) check_reg("R2", i, model[i]);

      // R3: upper-half alias
      do_write(1, 0, 64'h2, 0);
      do_write(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
      check_reg("R3", 1, 64'hC000_0000_0000_0002);
      do_write(1, 1, 64'h0, 0);
      check_reg("R3", 1, 64'h0000_0000_0000_0002);
      do_write(1, 0, 64'h0, 0);

      // R7/R8: layered enable and fault type
      set_chk(1, 0, 2'd1, 1, 1, 0, 1, 1, 0, 0);
      check_verdict("R8");
      set_chk(1, 0, 2'd1, 0, 1, 0, 1, 1, 0, 0);
      check_verdict("R7");
      set_chk(1, 0, 2'd0, 0, 1, 0, 1, 1, 0, 0);
      check_verdict("R7");
      set_chk(1, 0, 2'd0, 0, 1, 0, 1, 0, 0, 0);
      check_verdict("R7");
      // R4, R5, R6, R9, R10 directed
      set_chk(1, 0, 2'd3, 0, 1, 0, 0, 1, 0, 0);
      check_verdict("R4");
      set_chk(1, 0, 2'd0, 1, 1, 1, 1, 1, 0, 0);
      check_verdict("R5");
      set_chk(1, 0, 2'd3, 1, 1, 0, 1, 1, 0, 0);
      check_verdict("R6");
      set_chk(1, 0, 2'd0, 1, 0, 0, 1, 1, 0, 0);
      check_verdict("R6");
      set_chk(1, 1, 2'd1, 1, 1, 0, 1, 1, 1, 0);
      check_verdict("R9");
      set_chk(1, 1, 2'd1, 1, 1, 0, 1, 1, 0, 1);
      check_verdict("R9");
      set_chk(0, 0, 2'd1, 1, 1, 0, 1, 1, 0, 0);
      check_verdict("R10");

      // Random mix covering R2, R3, R7, R8, R10
      for (int it = 0; it < 800; it++) begin
         logic [31:0] r;
         r = $urandom;
         if (r[2:0] < 3) begin
            do_write(int'(r[4:3]), r[5], {$urandom, $urandom}, r[6]);
            check_reg("R2_R3_rand", int'(r[8:7] == 2'd3 ? 2'd0 : r[8:7]),
                      model[(r[8:7] == 2'd3) ? 0 : r[8:7]]);
         end
         r = $urandom;
         set_chk(r[0] | r[1], r[2], r[4:3], r[5], r[6] | r[7], r[8] & r[9] & r[10],
                 r[11] | r[12], r[13], r[14] & r[15], r[16] & r[17]);
         check_verdict("R7_R8_R10_rand");
      end

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule